// File: doc/BRIEF.md
# Three-Wire Bus Ownership Requester

This block is the master-side controller for a shared external bus that is arbitrated with three wires: a request output, a grant input and a "bus driven" output. An internal requester raises a level-sensitive pending flag when it has a transfer to run. The block then asks the external arbiter for the bus and takes explicit ownership once the grant is seen. It acknowledges the start of every transfer with a one-cycle pulse. It keeps ownership until the bus-cycle engine reports that the transfer is done, and then either runs the next pending transfer, parks as an idle owner, or gives the bus up through a turnaround window.

The bus-driven output and a vector of output-enable controls for the address, data and control groups change together. This means the drivers are released in the same cycle that ownership is dropped. A grant that is removed during a transfer never cuts that transfer short. The request output is only a "needs the bus" hint and does not encode the arbitration state.

Top module: `bus_arb_requester`

## Requirements
- R1: `bus_req` is registered. After a clock edge it is 1 exactly when `xfer_req` was 1 at that edge and the block did not move into an owning state (idle owner or explicit owner) at that edge.
- R2: If `bus_grant` and `xfer_req` are both 1 at an edge while the block is not owned or is an idle owner, then `bus_driven` is 1 after that edge and `xfer_ack` is 1 for exactly that one cycle.
- R3: Once `bus_driven` is 1, it stays 1 on every edge where `xfer_done` is 0, whatever the value of `bus_grant`.
- R4: At an edge where `xfer_done` is 1 and `bus_grant` is 0, `bus_driven` and `bus_oe` go to 0. The block then spends `TURN_CYC` cycles in turnaround and does not re-acquire the bus during them, even with grant and request present. It then returns to not owned.
- R5: If `bus_grant` is 1 at an edge with no pending transfer, the block becomes an idle owner with `bus_driven`, `bus_req` and `bus_oe` all 0. A request raised later while the grant holds gives `bus_driven` = 1 one edge later.
- R6: An idle owner that samples `bus_grant` = 0 becomes not owned. If `xfer_req` is 1 at that edge, `bus_req` is 1 after it.
- R7: `bus_oe` is all ones in exactly the cycles where `bus_driven` is 1 and all zeros otherwise. It falls in the same cycle as `bus_driven`.
- R8: At an edge where `xfer_done` is 1, `bus_grant` is 1, `xfer_req` is 1 and `xfer_ack` is 0, `bus_driven` stays 1 and `xfer_ack` pulses again (back-to-back transfer).
- R9: At an edge where `xfer_done` is 1, `bus_grant` is 1 and no new transfer is pending (`xfer_req` 0, or `xfer_ack` 1 in that cycle), `bus_driven` and `bus_oe` go to 0 and the block becomes an idle owner.
- R10: While `rst_n` is 0 at an edge, the block goes to not owned with `bus_req`, `bus_driven`, `xfer_ack` and `bus_oe` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_req | input | 1 | Internal transfer pending (level); dropped after `xfer_ack` is seen |
| xfer_done | input | 1 | Current bus transfer completes at this edge |
| bus_grant | input | 1 | Grant from the external arbiter, 1 = granted |
| xfer_ack | output | 1 | One-cycle pulse in the first cycle of each transfer |
| bus_req | output | 1 | Bus request hint to the arbiter |
| bus_driven | output | 1 | Explicit bus ownership indication |
| bus_oe | output | OE_W | Output enables for the external bus groups |

## Verification
The embedded assertions check the cycle-level rules on every clock: ownership is held until completion, request and ownership are mutually exclusive, a granted pending transfer starts on the next edge, completion without a grant drops both the driven flag and the enables, and a back-to-back start keeps ownership. Only the bench scenarios can show how the rules combine into sequences. These sequences are the refusal to re-acquire during turnaround, parking as an idle owner and later leaving or reusing that state, and the exact reset values.

// File: rtl/arb_pkg.sv
// Package: shared state type for the bus ownership requester.
// Assumes: nothing beyond a 2-bit state encoding.
package arb_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,   // bus not owned, drivers off
        ST_IDLE = 2'd1,   // granted but no transfer running, no driven flag
        ST_EXPL = 2'd2,   // driven flag set, transfer running
        ST_TURN = 2'd3    // ownership just dropped, drivers off
    } arb_state_t;
endpackage

// File: rtl/arb_next_state.sv
// Module: combinational next-state logic of the ownership FSM.
// Assumes: start_ok is a pending request not yet acknowledged; turn_last
// marks the final turnaround cycle.
module arb_next_state
    import arb_pkg::*;
(
    input  arb_state_t state,
    input  logic       bus_grant,
    input  logic       start_ok,
    input  logic       xfer_done,
    input  logic       turn_last,
    output arb_state_t nxt,
    output logic       start
);
    // Purpose: choose the next arbitration state and flag a new transfer start.
    always_comb begin
        nxt   = state;
        start = 1'b0;
        unique case (state)
            ST_FREE: begin
                if (bus_grant && start_ok) begin
                    nxt   = ST_EXPL;
                    start = 1'b1;
                end else if (bus_grant) begin
                    nxt = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (!bus_grant) begin
                    nxt = ST_FREE;
                end else if (start_ok) begin
                    nxt   = ST_EXPL;
                    start = 1'b1;
                end
            end
            ST_EXPL: begin
                if (xfer_done) begin
                    if (bus_grant && start_ok) begin
                        nxt   = ST_EXPL;
                        start = 1'b1;
                    end else if (bus_grant) begin
                        nxt = ST_IDLE;
                    end else begin
                        nxt = ST_TURN;
                    end
                end
            end
            ST_TURN: begin
                if (turn_last) begin
                    nxt = ST_FREE;
                end
            end
            default: nxt = ST_FREE;
        endcase
    end
endmodule

// File: rtl/arb_turn_timer.sv
// Module: counts the turnaround window after ownership is given up.
// Assumes: load is a one-cycle pulse on entry to turnaround; TURN_CYC >= 1.
module arb_turn_timer #(
    parameter int TURN_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int CW = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(TURN_CYC - 1);

    logic [CW-1:0] cnt;

    // Purpose: load on entry, count down while in turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/arb_out_regs.sv
// Module: registered outputs (request hint, driven flag, enables, ack).
// Assumes: nxt is the state the FSM enters at this edge.
module arb_out_regs
    import arb_pkg::*;
#(
    parameter int OE_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  arb_state_t      nxt,
    input  logic            start,
    input  logic            xfer_req,
    output logic            bus_req,
    output logic            bus_driven,
    output logic            xfer_ack,
    output logic [OE_W-1:0] bus_oe
);
    logic owned_next;
    logic drive_next;

    assign owned_next = (nxt == ST_IDLE) || (nxt == ST_EXPL);
    assign drive_next = (nxt == ST_EXPL);

    // Purpose: request hint, driven flag and start pulse, updated each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req    <= 1'b0;
            bus_driven <= 1'b0;
            xfer_ack   <= 1'b0;
        end else begin
            bus_req    <= xfer_req && !owned_next;
            bus_driven <= drive_next;
            xfer_ack   <= start;
        end
    end

    // One enable flop per bus group so each can be placed by its drivers.
    for (genvar g = 0; g < OE_W; g++) begin : g_oe
        // Purpose: enable for group g follows explicit ownership.
        always_ff @(posedge clk) begin
            if (!rst_n) bus_oe[g] <= 1'b0;
            else        bus_oe[g] <= drive_next;
        end
    end
endmodule

// File: rtl/bus_arb_requester.sv
// Module: top of the three-wire bus ownership requester.
// Assumes: xfer_req is a level held until xfer_ack is seen; xfer_done is
// only meaningful while bus_driven is 1; inputs are synchronous to clk.
module bus_arb_requester
    import arb_pkg::*;
#(
    parameter int OE_W     = 3,
    parameter int TURN_CYC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_req,
    input  logic            xfer_done,
    input  logic            bus_grant,
    output logic            xfer_ack,
    output logic            bus_req,
    output logic            bus_driven,
    output logic [OE_W-1:0] bus_oe
);
    arb_state_t state;
    arb_state_t nxt;
    logic       start;
    logic       start_ok;
    logic       turn_last;
    logic       turn_load;

    assign start_ok  = xfer_req && !xfer_ack;
    assign turn_load = (nxt == ST_TURN) && (state != ST_TURN);

    arb_next_state u_nxt (
        .state     (state),
        .bus_grant (bus_grant),
        .start_ok  (start_ok),
        .xfer_done (xfer_done),
        .turn_last (turn_last),
        .nxt       (nxt),
        .start     (start)
    );

    arb_turn_timer #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (turn_load),
        .last  (turn_last)
    );

    arb_out_regs #(.OE_W(OE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt        (nxt),
        .start      (start),
        .xfer_req   (xfer_req),
        .bus_req    (bus_req),
        .bus_driven (bus_driven),
        .xfer_ack   (xfer_ack),
        .bus_oe     (bus_oe)
    );

    // Purpose: arbitration state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= nxt;
    end

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_driven && !xfer_done) |=> bus_driven);                            // R3
    AST_REQ_NOT_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_driven |-> !bus_req);                                              // R1
    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_driven && state != ST_TURN && bus_grant && xfer_req) |=> (bus_driven && xfer_ack)); // R2
    AST_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_driven && xfer_done && !bus_grant) |=> (!bus_driven && bus_oe == '0)); // R4
    AST_OE_TRACKS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_driven |-> (bus_oe == '0));                                       // R7
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_driven && xfer_done && bus_grant && xfer_req && !xfer_ack) |=> (bus_driven && xfer_ack)); // R8
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && !xfer_done) |=> !xfer_ack);                               // R2
endmodule

// File: tb/sim_bus_arb_requester.sv
module sim_bus_arb_requester;
    localparam int OE_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            xfer_req = 1'b0;
    logic            xfer_done = 1'b0;
    logic            bus_grant = 1'b0;
    logic            xfer_ack;
    logic            bus_req;
    logic            bus_driven;
    logic [OE_W-1:0] bus_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_arb_requester #(.OE_W(OE_W), .TURN_CYC(1)) u0 (
        .clk, .rst_n, .xfer_req, .xfer_done, .bus_grant,
        .xfer_ack, .bus_req, .bus_driven, .bus_oe
    );

    // Advance one edge; outputs are then read 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare all outputs with expected values in one check.
    task automatic expect_out(string req, logic ack, logic br, logic bd, logic oe);
        logic [OE_W-1:0] oe_exp;
        oe_exp = {OE_W{oe}};
        n_chk++;
        if (xfer_ack !== ack || bus_req !== br || bus_driven !== bd || bus_oe !== oe_exp) begin
            n_bad++;
            $display("FAIL %s: ack/br/bd/oe = %b/%b/%b/%b expected %b/%b/%b/%b",
                     req, xfer_ack, bus_req, bus_driven, bus_oe, ack, br, bd, oe_exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; xfer_req = 1'b0; xfer_done = 1'b0; bus_grant = 1'b0;
        step(); step();
        expect_out("R10 reset values", 0, 0, 0, 0);
        rst_n = 1'b1;
        step();
        expect_out("R10 idle after reset", 0, 0, 0, 0);
    endtask

    task automatic t_acquire_and_hold();
        xfer_req = 1'b1;
        step();
        expect_out("R1 request without grant", 0, 1, 0, 0);
        bus_grant = 1'b1;
        step();
        expect_out("R2 grant starts transfer", 1, 0, 1, 1);
        xfer_req = 1'b0;
        step();
        expect_out("R2 ack is one cycle", 0, 0, 1, 1);
        bus_grant = 1'b0;
        step(); step();
        expect_out("R3 hold after grant removed", 0, 0, 1, 1);
        xfer_done = 1'b1;
        step();
        expect_out("R4 R7 drop on done without grant", 0, 0, 0, 0);
        xfer_done = 1'b0; bus_grant = 1'b1; xfer_req = 1'b1;
        step();
        expect_out("R4 no reacquire in turnaround", 0, 1, 0, 0);
        step();
        expect_out("R2 reacquire after turnaround", 1, 0, 1, 1);
    endtask

    task automatic t_back_to_back();
        xfer_req = 1'b0;
        step();
        expect_out("R8 first transfer running", 0, 0, 1, 1);
        xfer_req = 1'b1; xfer_done = 1'b1;
        step();
        expect_out("R8 back-to-back keeps ownership", 1, 0, 1, 1);
        xfer_req = 1'b0;
        step();
        expect_out("R9 done with grant and nothing pending", 0, 0, 0, 0);
        xfer_done = 1'b0;
    endtask

    task automatic t_idle_owner();
        step();
        expect_out("R5 idle owner stays quiet", 0, 0, 0, 0);
        xfer_req = 1'b1;
        step();
        expect_out("R5 request while idle owner", 1, 0, 1, 1);
        xfer_req = 1'b0; xfer_done = 1'b1; bus_grant = 1'b0;
        step();
        expect_out("R4 release from idle-owner transfer", 0, 0, 0, 0);
        xfer_done = 1'b0;
        step();
        bus_grant = 1'b1;
        step();
        expect_out("R5 grant without pending", 0, 0, 0, 0);
        bus_grant = 1'b0; xfer_req = 1'b1;
        step();
        expect_out("R6 idle owner loses grant", 0, 1, 0, 0);
        step();
        expect_out("R6 still not owned", 0, 1, 0, 0);
        xfer_req = 1'b0;
        step();
        expect_out("R1 request hint clears", 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_acquire_and_hold();
        t_back_to_back();
        t_idle_owner();
        t_reset();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule